// File: doc/BRIEF.md
# Two-Mode ADSR Envelope Generator

This block produces the attenuation envelope of one synthesis operator over a 48 dB range. A key-on event starts an attack from silence toward full level. A decay then falls to a programmable sustain level. What follows depends on the mode input. In sustained mode the level is held until key-off and then released. In decaying mode the level keeps falling at the release rate, and a key-off switches it to a fixed medium release. A second input replaces the release rate with a fixed slow code. A key-on that arrives while a sound is still audible first pulls the level down to silence at a fast fixed rate, and only then starts the new attack. This keeps the operators of one voice in step.

Attenuation is kept in units of 0.75 dB, so 64 units means silence (48 dB). Rates are 4-bit codes. Each code is turned into a step period, counted in pulses of a fixed sample `tick`. Each code step halves or doubles that period. A 6-bit total level is added to the envelope at the output, and the result saturates at silence. The phase output reports the state with this encoding: 0 OFF, 1 ATTACK, 2 DECAY, 3 HOLD, 4 FADE, 5 RELEASE, 6 DAMP.

The transitions are as follows. OFF goes to ATTACK on key-on. Any other state goes to DAMP on key-on. DAMP goes to ATTACK at silence. ATTACK goes to DECAY at 0 units. DECAY goes to HOLD (sustained mode) or to FADE (decaying mode) at the sustain target. ATTACK, DECAY, HOLD and FADE go to RELEASE on key-off. FADE and RELEASE go to OFF at silence.

Top module: `adsr_env_gen`

## Requirements
- R1: After reset, phase is OFF (0), idle is 1 and atten is 64.
- R2: A key-on in OFF gives phase ATTACK (1) one cycle later. In ATTACK the envelope drops by 1 unit every 2^(14-code) ticks. Code 15 reaches 0 on the first tick. Codes 0 and 1 never move the envelope.
- R3: In DECAY the envelope rises by 1 unit every 2*2^(14-code) ticks, or by 2 units every tick for code 15. It is clamped at the target 4*sustain_lvl. Codes 0 and 1 hold the level.
- R4: With hold_mode=1, the envelope stays at the sustain target (HOLD, 3) until key-off. It then releases at release_rate, or at code 6 when long_tail=1.
- R5: With hold_mode=0, reaching the target enters FADE (4), which rises at release_rate. A key-off then releases at code 9, or at code 6 when long_tail=1.
- R6: A key-off in ATTACK, DECAY, HOLD or FADE gives RELEASE (5) one cycle later. In OFF, DAMP and RELEASE a key-off has no effect.
- R7: A key-on in any state other than OFF gives DAMP (6) one cycle later, even if key-off is present in the same cycle. DAMP rises by 1 unit every 2 ticks (code 14 decay) to 64 and then enters ATTACK.
- R8: When the envelope reaches 64 in FADE or RELEASE, the next cycle shows phase OFF with idle=1.
- R9: atten equals min(envelope + total_lvl, 64), combinationally from total_lvl.
- R10: Step counters advance only on tick cycles and restart on every state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick that paces all rates |
| key_on | input | 1 | Single-cycle key-on event |
| key_off | input | 1 | Single-cycle key-off (sound length end) event |
| attack_rate | input | 4 | Attack rate code |
| decay_rate | input | 4 | Decay rate code |
| release_rate | input | 4 | Release rate code |
| sustain_lvl | input | 4 | Sustain level in 3 dB units |
| total_lvl | input | 6 | Total level in 0.75 dB units |
| hold_mode | input | 1 | 1 = sustained mode, 0 = decaying mode |
| long_tail | input | 1 | 1 = release uses fixed code 6 |
| atten | output | 7 | Attenuation in 0.75 dB units, 64 = silent |
| phase | output | 3 | Current state code |
| idle | output | 1 | High in OFF |

## Verification
A wrong state or a misloaded step counter shows at the ports within one step period. A wrong state shows at once as a phase code that differs from the reference model. A miscounted counter shows as atten moving one tick early or late. The bench compares phase, idle and atten against a behavioural model on every cycle. A slip in the counter restart or in the clamp to the sustain target is therefore caught on the first cycle where the model and the design disagree. Slow codes are still exercised for a few exact steps.

// File: rtl/adsr_eg_pkg.sv
package adsr_eg_pkg;

    typedef enum logic [2:0] {
        EG_OFF     = 3'd0,
        EG_ATTACK  = 3'd1,
        EG_DECAY   = 3'd2,
        EG_HOLD    = 3'd3,
        EG_FADE    = 3'd4,
        EG_RELEASE = 3'd5,
        EG_DAMP    = 3'd6
    } eg_state_e;

    localparam logic [3:0] DAMP_CODE    = 4'hE;
    localparam logic [3:0] KEYUP_CODE   = 4'h9;
    localparam logic [3:0] TAIL_CODE    = 4'h6;
    localparam logic [3:0] FASTEST_CODE = 4'hF;

endpackage

// File: rtl/eg_step_timer.sv
module eg_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic       rise,
    input  logic [3:0] code,
    output logic       step
);
    import adsr_eg_pkg::*;

    localparam logic [3:0] SLOW_EDGE = 4'd14;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;
    logic             active;
    logic             at_end;

    always_comb begin
        active = (code >= 4'd2);
        if (code == FASTEST_CODE)
            period = CNT_W'(1);
        else if (rise)
            period = CNT_W'(1) << (SLOW_EDGE - code);
        else
            period = CNT_W'(2) << (SLOW_EDGE - code);
        at_end = (cnt_q >= period - CNT_W'(1));
        step   = tick && active && !restart && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (tick && active)
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/eg_level_sum.sv
module eg_level_sum #(
    parameter int ENV_W = 7,
    parameter int TL_W  = 6
) (
    input  logic [ENV_W-1:0] env,
    input  logic [TL_W-1:0]  tl,
    output logic [ENV_W-1:0] atten
);
    localparam logic [ENV_W:0] FLOOR = (ENV_W+1)'(1) << (ENV_W-1);

    logic [ENV_W:0] sum;

    always_comb begin
        sum   = {1'b0, env} + (ENV_W+1)'(tl);
        atten = (sum >= FLOOR) ? FLOOR[ENV_W-1:0] : sum[ENV_W-1:0];
    end

endmodule

// File: rtl/adsr_env_gen.sv
module adsr_env_gen #(
    parameter int ENV_W = 7,
    parameter int SL_W  = 4,
    parameter int TL_W  = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_on,
    input  logic             key_off,
    input  logic [3:0]       attack_rate,
    input  logic [3:0]       decay_rate,
    input  logic [3:0]       release_rate,
    input  logic [SL_W-1:0]  sustain_lvl,
    input  logic [TL_W-1:0]  total_lvl,
    input  logic             hold_mode,
    input  logic             long_tail,
    output logic [ENV_W-1:0] atten,
    output logic [2:0]       phase,
    output logic             idle
);
    import adsr_eg_pkg::*;

    localparam logic [ENV_W-1:0] SILENT = ENV_W'(1) << (ENV_W-1);

    eg_state_e        state_q, state_d;
    logic [ENV_W-1:0] env_q, env_d;
    logic [ENV_W-1:0] sl_target;
    logic [ENV_W-1:0] ceiling;
    logic [ENV_W:0]   rise_sum;
    logic [1:0]       amt;
    logic [3:0]       rate_code;
    logic             rise;
    logic             restart;
    logic             step;

    assign sl_target = ENV_W'({sustain_lvl, 2'b00});
    assign restart   = (state_d != state_q);

    // transition selection
    always_comb begin
        state_d = state_q;
        if (key_on) begin
            state_d = (state_q == EG_OFF) ? EG_ATTACK : EG_DAMP;
        end else if (key_off && (state_q inside {EG_ATTACK, EG_DECAY, EG_HOLD, EG_FADE})) begin
            state_d = EG_RELEASE;
        end else begin
            unique case (state_q)
                EG_DAMP:    if (env_q == SILENT) state_d = EG_ATTACK;
                EG_ATTACK:  if (env_q == '0) state_d = EG_DECAY;
                EG_DECAY:   if (env_q >= sl_target) state_d = hold_mode ? EG_HOLD : EG_FADE;
                EG_FADE,
                EG_RELEASE: if (env_q == SILENT) state_d = EG_OFF;
                default:    ;
            endcase
        end
    end

    // rate selection per state
    always_comb begin
        rise      = 1'b0;
        rate_code = 4'd0;
        ceiling   = SILENT;
        unique case (state_q)
            EG_ATTACK: begin
                rise      = 1'b1;
                rate_code = attack_rate;
            end
            EG_DECAY: begin
                rate_code = decay_rate;
                ceiling   = sl_target;
            end
            EG_FADE:    rate_code = release_rate;
            EG_RELEASE: rate_code = long_tail ? TAIL_CODE
                                  : (hold_mode ? release_rate : KEYUP_CODE);
            EG_DAMP:    rate_code = DAMP_CODE;
            default:    rate_code = 4'd0;
        endcase
    end

    eg_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .rise    (rise),
        .code    (rate_code),
        .step    (step)
    );

    // envelope update
    always_comb begin
        env_d    = env_q;
        amt      = (rate_code == FASTEST_CODE) ? 2'd2 : 2'd1;
        rise_sum = {1'b0, env_q} + {{(ENV_W-1){1'b0}}, amt};
        if (step) begin
            if (rise)
                env_d = ((rate_code == FASTEST_CODE) || (env_q == '0)) ? '0 : env_q - ENV_W'(1);
            else
                env_d = (rise_sum >= {1'b0, ceiling}) ? ceiling : rise_sum[ENV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EG_OFF;
            env_q   <= SILENT;
        end else begin
            state_q <= state_d;
            env_q   <= env_d;
        end
    end

    // outputs
    always_comb begin
        phase = state_q;
        idle  = (state_q == EG_OFF);
    end

    eg_level_sum #(.ENV_W(ENV_W), .TL_W(TL_W)) u_sum (
        .env   (env_q),
        .tl    (total_lvl),
        .atten (atten)
    );

endmodule

// File: rtl/adsr_env_gen_chk.sv
module adsr_env_gen_chk #(
    parameter int ENV_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_on,
    input logic             key_off,
    input logic [2:0]       phase,
    input logic [ENV_W-1:0] env,
    input logic [ENV_W-1:0] atten,
    input logic             idle
);
    import adsr_eg_pkg::*;

    localparam logic [ENV_W-1:0] SILENT = ENV_W'(1) << (ENV_W-1);

    a_r9_atten_bound: assert property (@(posedge clk) disable iff (!rst_n)
        atten <= SILENT);

    a_r2_keyon_from_off: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on && phase == EG_OFF) |=> phase == EG_ATTACK);

    a_r2_attack_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == EG_ATTACK && $past(phase) == EG_ATTACK) |-> env <= $past(env));

    a_r4_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == EG_HOLD && $past(phase) == EG_HOLD) |-> $stable(env));

    a_r5_release_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == EG_RELEASE && $past(phase) == EG_RELEASE) |-> env >= $past(env));

    a_r6_keyoff_release: assert property (@(posedge clk) disable iff (!rst_n)
        (key_off && !key_on && (phase inside {EG_ATTACK, EG_DECAY, EG_HOLD, EG_FADE}))
        |=> phase == EG_RELEASE);

    a_r7_keyon_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on && phase != EG_OFF) |=> phase == EG_DAMP);

    a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> atten == SILENT);

    a_r8_reach_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase inside {EG_FADE, EG_RELEASE}) && env == SILENT && !key_on) |=> idle);

endmodule

bind adsr_env_gen adsr_env_gen_chk #(.ENV_W(ENV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_on  (key_on),
    .key_off (key_off),
    .phase   (phase),
    .env     (env_q),
    .atten   (atten),
    .idle    (idle)
);

// File: tb/tb_adsr_env_gen.sv
module tb_adsr_env_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SILENT     = 64;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       key_on = 1'b0;
    logic       key_off = 1'b0;
    logic [3:0] ar = 4'd0, dr = 4'd0, rr = 4'd0, sl = 4'd0;
    logic [5:0] tl = 6'd0;
    logic       hold_mode = 1'b0;
    logic       long_tail = 1'b0;
    logic [6:0] atten;
    logic [2:0] phase;
    logic       idle;

    always #(CLK_PERIOD/2) clk = ~clk;

    adsr_env_gen dut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .key_on (key_on), .key_off (key_off),
        .attack_rate (ar), .decay_rate (dr), .release_rate (rr),
        .sustain_lvl (sl), .total_lvl (tl),
        .hold_mode (hold_mode), .long_tail (long_tail),
        .atten (atten), .phase (phase), .idle (idle)
    );

    int    checks = 0, errors = 0, cycles = 0, tick_div = 1, tcount = 0;
    string tag = "R1";

    // behavioural reference model: 0 OFF,1 ATT,2 DEC,3 HOLD,4 FADE,5 REL,6 DAMP
    int ms = 0, me = SILENT, mc = 0;
    int ns, code, per, lim, amt;
    bit rise;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; me = SILENT; mc = 0;
        end else begin
            ns = ms;
            if (key_on) ns = (ms == 0) ? 1 : 6;
            else if (key_off && ms >= 1 && ms <= 4) ns = 5;
            else case (ms)
                6: if (me == SILENT) ns = 1;
                1: if (me == 0) ns = 2;
                2: if (me >= int'(sl) * 4) ns = hold_mode ? 3 : 4;
                4, 5: if (me == SILENT) ns = 0;
                default: ;
            endcase
            rise = (ms == 1); lim = SILENT;
            case (ms)
                1: code = int'(ar);
                2: begin code = int'(dr); lim = int'(sl) * 4; end
                4: code = int'(rr);
                5: code = long_tail ? 6 : (hold_mode ? int'(rr) : 9);
                6: code = 14;
                default: code = 0;
            endcase
            if (ns != ms) mc = 0;
            else if (tick && code >= 2) begin
                per = (code == 15) ? 1 : (rise ? (1 << (14 - code)) : (2 << (14 - code)));
                if (mc >= per - 1) begin
                    mc = 0;
                    if (rise) me = (code == 15) ? 0 : ((me > 0) ? me - 1 : 0);
                    else begin
                        amt = (code == 15) ? 2 : 1;
                        me = (me + amt > lim) ? lim : me + amt;
                    end
                end else mc = mc + 1;
            end
            ms = ns;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic compare();
        int ea;
        ea = me + int'(tl);
        if (ea > SILENT) ea = SILENT;
        checks++;
        if (atten !== 7'(ea) || phase !== 3'(ms) || idle !== (ms == 0)) begin
            errors++;
            $display("FAIL %s: atten/phase/idle = %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, atten, phase, idle, ea, ms, (ms == 0));
        end
    endtask

    task automatic adv(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            key_on = 1'b0;
            key_off = 1'b0;
            tcount++;
            tick = ((tcount % tick_div) == 0);
        end
    endtask

    task automatic expect_eq(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        expect_eq("R1", "phase", int'(phase), 0);
        expect_eq("R1", "idle", int'(idle), 1);
        expect_eq("R1", "atten", int'(atten), 64);
        rst_n = 1'b1;
        tick = 1'b1;

        // R2 R3 R4: sustained mode, full cycle
        tag = "R2"; hold_mode = 1; ar = 4'hE; dr = 4'hD; sl = 4'd2; rr = 4'hE; tl = 0;
        adv(1); key_on = 1;
        adv(1);
        expect_eq("R2", "phase after key-on", int'(phase), 1);
        adv(70);
        tag = "R3"; adv(45);
        expect_eq("R4", "phase at sustain", int'(phase), 3);
        expect_eq("R3", "atten at sustain", int'(atten), 8);
        tag = "R9"; tl = 6'd63; adv(3);
        expect_eq("R9", "saturated atten", int'(atten), 64);
        tl = 6'd5; adv(2);
        expect_eq("R9", "env plus tl", int'(atten), 13);
        tl = 0;
        tag = "R4"; key_off = 1; adv(1);
        expect_eq("R6", "phase after key-off in hold", int'(phase), 5);
        tag = "R8"; adv(130);
        expect_eq("R8", "idle after release", int'(idle), 1);

        // R5: decaying mode, fast attack, keyup release then R7 damp
        tag = "R5"; hold_mode = 0; ar = 4'hF; dr = 4'hE; sl = 4'd1; rr = 4'hC;
        key_on = 1; adv(1); adv(2);
        expect_eq("R2", "atten after code F attack", int'(atten), 0);
        adv(20);
        expect_eq("R5", "phase in fade", int'(phase), 4);
        adv(40);
        key_off = 1; adv(1);
        adv(200);
        expect_eq("R5", "phase in keyup release", int'(phase), 5);
        tag = "R7"; key_on = 1; adv(1);
        expect_eq("R7", "phase after busy key-on", int'(phase), 6);
        adv(120);
        tag = "R5"; adv(600);
        expect_eq("R8", "idle after fade", int'(idle), 1);

        // R4 long tail, then R2 codes 0/1 attack
        tag = "R4"; hold_mode = 1; long_tail = 1; ar = 4'hE; dr = 4'hF; sl = 4'd0; rr = 4'hF;
        key_on = 1; adv(1); adv(70);
        expect_eq("R4", "phase hold at sl 0", int'(phase), 3);
        expect_eq("R4", "atten hold at sl 0", int'(atten), 0);
        key_off = 1; adv(1);
        adv(1100);
        expect_eq("R4", "long tail atten", int'(atten), 2);
        tag = "R7"; ar = 4'd1; key_on = 1; adv(1);
        expect_eq("R7", "damp entry", int'(phase), 6);
        tag = "R2"; adv(200);
        expect_eq("R2", "stalled attack phase", int'(phase), 1);
        expect_eq("R2", "stalled attack atten", int'(atten), 64);
        tag = "R8"; key_off = 1; adv(1);
        expect_eq("R6", "release at silence", int'(phase), 5);
        adv(1);
        expect_eq("R8", "off after silent release", int'(idle), 1);

        // R6: ignored key-offs, key-off in attack
        tag = "R6"; long_tail = 0; rr = 4'hE; ar = 4'hC;
        key_off = 1; adv(1);
        expect_eq("R6", "key-off in off phase", int'(phase), 0);
        expect_eq("R6", "key-off in off idle", int'(idle), 1);
        key_on = 1; adv(1); adv(20);
        key_off = 1; adv(1);
        expect_eq("R6", "key-off in attack", int'(phase), 5);
        adv(4);
        tag = "R7"; key_on = 1; key_off = 1; adv(1);
        expect_eq("R7", "key-on wins over key-off", int'(phase), 6);
        tag = "R6"; key_off = 1; adv(1);
        expect_eq("R6", "key-off in damp", int'(phase), 6);

        // R10: sparse ticks
        tag = "R10"; tick_div = 3;
        adv(1200);
        tick_div = 1;
        key_off = 1; adv(1);
        adv(200);
        expect_eq("R10", "idle at end", int'(idle), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule